// File: doc/BRIEF.md
# Security-Aware Interrupt Priority Resolver

This block chooses which pending interrupt line should be taken next in a processor that runs in a secure and a non-secure execution state. Every line has a 3-bit raw priority and a target-state bit that says whether its handler runs secure or non-secure. The raw value becomes an 8-bit effective level. One remap control bit can move every non-secure line into the lower-priority half of the level space. Interrupt masks are kept separately for each state, but both sets act on the one shared level space. A mask set by either state can therefore hold back lines that target the other state.

The resolver looks at all lines in one cycle and registers the result. It reports the winning line's index, its target state and its effective level. It also raises a preempt request when that level is strictly better than the level the core is executing at. The remap bit and the target-state bits sit behind a small configuration port that accepts writes only when they are marked secure. The same port reads the stored values back.

Top module: `irq_sec_arbiter`

## Requirements
- R1: The effective level of a line is its raw priority placed in bits [7:5] of an 8-bit value, with the low bits zero. A lower effective level wins over a higher one.
- R2: The remap control bit resets to 0. While it is 0, non-secure lines use the same level mapping as secure lines.
- R3: While the remap bit is 1, a non-secure line with raw priority p has effective level 0x80 + 16*p. This gives 0x80 up to 0xF0. Secure lines keep their mapping.
- R4: Every target-state bit resets to 0, which means secure. A 1 means non-secure. The reported state of the winner (irq_ns_o) is its target-state bit.
- R5: A configuration write with cfg_sec_i low changes neither the remap bit nor any target-state bit.
- R6: While either state's all-block mask input is high, no line is granted.
- R7: A nonzero threshold from either state blocks every line whose effective level is at or above that threshold, whatever the line's target state. A threshold of zero blocks nothing.
- R8: When several eligible lines share the best effective level, the lowest line index wins.
- R9: preempt_o is high exactly when a winner is reported and its effective level, widened to 9 bits, is strictly below cur_level_i.
- R10: Outputs are registered. Each edge reports the result for the inputs and configuration present just before it. With no eligible line, and during reset, all outputs are zero.
- R11: cfg_sel_i = 0 selects the control word, whose bit 0 is the remap bit. cfg_sel_i = 1 selects the target word, whose bit i is line i's target state. A secure write takes effect at the clock edge. cfg_rdata_o returns the selected word combinationally, with unused control bits reading 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pend_i | input | 32 | Pending flag per line |
| prio_i | input | 96 | Raw 3-bit priority per line; line i at bits [3i+2:3i] |
| cur_level_i | input | 9 | Level the core currently executes at (0x100 = thread, nothing active) |
| s_pmask_i | input | 1 | Secure all-block mask |
| ns_pmask_i | input | 1 | Non-secure all-block mask |
| s_bpri_i | input | 8 | Secure threshold mask, 0 = off |
| ns_bpri_i | input | 8 | Non-secure threshold mask, 0 = off |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_sec_i | input | 1 | Write is issued by secure software |
| cfg_sel_i | input | 1 | Word select: 0 control, 1 target |
| cfg_wdata_i | input | 32 | Write data |
| cfg_rdata_o | output | 32 | Read data of the selected word |
| irq_valid_o | output | 1 | A line is granted |
| irq_id_o | output | 5 | Index of the granted line |
| irq_ns_o | output | 1 | Target state of the granted line (1 = non-secure) |
| irq_level_o | output | 8 | Effective level of the granted line |
| preempt_o | output | 1 | Granted line outranks the current execution level |

## Verification
The checker watches several properties on every cycle. Non-secure writes must never alter the configuration. An asserted all-block mask must always be followed by no grant, and no granted level may sit at or above an active threshold. Grant fields must be zero when idle, preempt must agree with the registered level against the current level, and granted levels must have the shape the mapping allows. Some behaviours can only be shown by the bench's directed scenarios and its per-cycle reference model. These are the exact choice among competing lines, the lowest-index tie rule, the interaction of a remapped non-secure line with a secure line at 0x80, and the read-back values after reset and after secure writes.

// File: rtl/irq_sec_pkg.sv
package irq_sec_pkg;

    // Width of the effective priority level and of the raw field
    localparam int LVL_W = 8;
    localparam int RAW_W = 3;

    // Configuration word selector
    typedef enum logic {
        SEL_CTRL   = 1'b0,
        SEL_TARGET = 1'b1
    } cfg_sel_e;

    // One candidate line after mapping and masking
    typedef struct packed {
        logic             vld;
        logic             ns;
        logic [LVL_W-1:0] lvl;
    } cand_t;

endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
    import irq_sec_pkg::*;
#(
    parameter int NUM_LINES = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_i,
    input  logic                 sec_i,
    input  logic                 sel_i,
    input  logic [NUM_LINES-1:0] wdata_i,
    output logic                 remap_o,
    output logic [NUM_LINES-1:0] tgt_ns_o,
    output logic [NUM_LINES-1:0] rdata_o
);

    logic                 remap_q;
    logic [NUM_LINES-1:0] tgt_q;
    cfg_sel_e             sel;

    assign sel = cfg_sel_e'(sel_i);

    // Only writes flagged secure reach the storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remap_q <= 1'b0;
            tgt_q   <= '0;
        end else if (wr_i && sec_i) begin
            unique case (sel)
                SEL_CTRL:   remap_q <= wdata_i[0];
                SEL_TARGET: tgt_q   <= wdata_i;
            endcase
        end
    end

    always_comb begin
        unique case (sel)
            SEL_CTRL:   rdata_o = {{(NUM_LINES-1){1'b0}}, remap_q};
            SEL_TARGET: rdata_o = tgt_q;
        endcase
    end

    assign remap_o  = remap_q;
    assign tgt_ns_o = tgt_q;

endmodule

// File: rtl/irq_line_eval.sv
module irq_line_eval
    import irq_sec_pkg::*;
#(
    parameter int NUM_LINES = 32
) (
    input  logic [NUM_LINES-1:0]       pend_i,
    input  logic [NUM_LINES*RAW_W-1:0] prio_i,
    input  logic [NUM_LINES-1:0]       tgt_ns_i,
    input  logic                       remap_i,
    input  logic                       s_pmask_i,
    input  logic                       ns_pmask_i,
    input  logic [LVL_W-1:0]           s_bpri_i,
    input  logic [LVL_W-1:0]           ns_bpri_i,
    output cand_t                      cand_o [NUM_LINES]
);

    localparam int PAD_W = LVL_W - RAW_W;

    logic s_thr_on, ns_thr_on, all_block;

    assign s_thr_on  = (s_bpri_i != '0);
    assign ns_thr_on = (ns_bpri_i != '0);
    assign all_block = s_pmask_i | ns_pmask_i;

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        logic [RAW_W-1:0] raw;
        logic [LVL_W-1:0] base, eff;
        logic             s_hit, ns_hit;

        assign raw  = prio_i[i*RAW_W +: RAW_W];
        assign base = {raw, {PAD_W{1'b0}}};
        // Remapped non-secure lines land in the lower half: 0x80 | base>>1
        assign eff  = (tgt_ns_i[i] && remap_i) ? {1'b1, base[LVL_W-1:1]} : base;

        // Both states' thresholds act on the shared level space
        assign s_hit  = s_thr_on  && (eff >= s_bpri_i);
        assign ns_hit = ns_thr_on && (eff >= ns_bpri_i);

        assign cand_o[i].vld = pend_i[i] && !all_block && !s_hit && !ns_hit;
        assign cand_o[i].ns  = tgt_ns_i[i];
        assign cand_o[i].lvl = eff;
    end

endmodule

// File: rtl/irq_pick_tree.sv
module irq_pick_tree
    import irq_sec_pkg::*;
#(
    parameter int NUM_LINES = 32
) (
    input  cand_t                     cand_i [NUM_LINES],
    output cand_t                     win_o,
    output logic [$clog2(NUM_LINES)-1:0] win_idx_o
);

    localparam int IDX_W = $clog2(NUM_LINES);
    localparam int LEAVES = 1 << IDX_W;
    localparam int NODES  = 2 * LEAVES - 1;

    cand_t            node [NODES];
    logic [IDX_W-1:0] nidx [NODES];

    // Leaves: real lines, then empty padding
    for (genvar j = 0; j < LEAVES; j++) begin : g_leaf
        if (j < NUM_LINES) begin : g_real
            assign node[LEAVES-1+j] = cand_i[j];
        end else begin : g_pad
            assign node[LEAVES-1+j] = '0;
        end
        assign nidx[LEAVES-1+j] = IDX_W'(j);
    end

    // Inner nodes: left child holds lower indices and wins ties
    for (genvar k = 0; k < LEAVES - 1; k++) begin : g_node
        logic take_r;
        assign take_r = node[2*k+2].vld &&
                        (!node[2*k+1].vld || (node[2*k+2].lvl < node[2*k+1].lvl));
        assign node[k] = take_r ? node[2*k+2] : node[2*k+1];
        assign nidx[k] = take_r ? nidx[2*k+2] : nidx[2*k+1];
    end

    assign win_o     = node[0];
    assign win_idx_o = nidx[0];

endmodule

// File: rtl/irq_sec_arbiter.sv
module irq_sec_arbiter
    import irq_sec_pkg::*;
#(
    parameter int NUM_LINES = 32,
    localparam int IDX_W = $clog2(NUM_LINES)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_LINES-1:0]       pend_i,
    input  logic [NUM_LINES*RAW_W-1:0] prio_i,
    input  logic [LVL_W:0]             cur_level_i,
    input  logic                       s_pmask_i,
    input  logic                       ns_pmask_i,
    input  logic [LVL_W-1:0]           s_bpri_i,
    input  logic [LVL_W-1:0]           ns_bpri_i,
    input  logic                       cfg_wr_i,
    input  logic                       cfg_sec_i,
    input  logic                       cfg_sel_i,
    input  logic [NUM_LINES-1:0]       cfg_wdata_i,
    output logic [NUM_LINES-1:0]       cfg_rdata_o,
    output logic                       irq_valid_o,
    output logic [IDX_W-1:0]           irq_id_o,
    output logic                       irq_ns_o,
    output logic [LVL_W-1:0]           irq_level_o,
    output logic                       preempt_o
);

    logic                 remap_w;
    logic [NUM_LINES-1:0] tgt_w;
    cand_t                cand [NUM_LINES];
    cand_t                win;
    logic [IDX_W-1:0]     win_idx;
    logic                 win_pre;

    irq_cfg_regs #(.NUM_LINES(NUM_LINES)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (cfg_wr_i),
        .sec_i    (cfg_sec_i),
        .sel_i    (cfg_sel_i),
        .wdata_i  (cfg_wdata_i),
        .remap_o  (remap_w),
        .tgt_ns_o (tgt_w),
        .rdata_o  (cfg_rdata_o)
    );

    irq_line_eval #(.NUM_LINES(NUM_LINES)) u_eval (
        .pend_i     (pend_i),
        .prio_i     (prio_i),
        .tgt_ns_i   (tgt_w),
        .remap_i    (remap_w),
        .s_pmask_i  (s_pmask_i),
        .ns_pmask_i (ns_pmask_i),
        .s_bpri_i   (s_bpri_i),
        .ns_bpri_i  (ns_bpri_i),
        .cand_o     (cand)
    );

    irq_pick_tree #(.NUM_LINES(NUM_LINES)) u_tree (
        .cand_i    (cand),
        .win_o     (win),
        .win_idx_o (win_idx)
    );

    assign win_pre = win.vld && ({1'b0, win.lvl} < cur_level_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_valid_o <= 1'b0;
            irq_id_o    <= '0;
            irq_ns_o    <= 1'b0;
            irq_level_o <= '0;
            preempt_o   <= 1'b0;
        end else if (win.vld) begin
            irq_valid_o <= 1'b1;
            irq_id_o    <= win_idx;
            irq_ns_o    <= win.ns;
            irq_level_o <= win.lvl;
            preempt_o   <= win_pre;
        end else begin
            irq_valid_o <= 1'b0;
            irq_id_o    <= '0;
            irq_ns_o    <= 1'b0;
            irq_level_o <= '0;
            preempt_o   <= 1'b0;
        end
    end

endmodule

// File: rtl/irq_sec_arbiter_chk.sv
module irq_sec_arbiter_chk
    import irq_sec_pkg::*;
#(
    parameter int NUM_LINES = 32,
    localparam int IDX_W = $clog2(NUM_LINES)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cfg_wr_i,
    input logic                 cfg_sec_i,
    input logic                 remap_w,
    input logic [NUM_LINES-1:0] tgt_w,
    input logic                 s_pmask_i,
    input logic                 ns_pmask_i,
    input logic [LVL_W-1:0]     s_bpri_i,
    input logic [LVL_W-1:0]     ns_bpri_i,
    input logic [LVL_W:0]       cur_level_i,
    input logic                 irq_valid_o,
    input logic [IDX_W-1:0]     irq_id_o,
    input logic                 irq_ns_o,
    input logic [LVL_W-1:0]     irq_level_o,
    input logic                 preempt_o
);

    localparam int PAD_W = LVL_W - RAW_W;

    // R5
    ns_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_i && !cfg_sec_i) |=> ($stable(remap_w) && $stable(tgt_w)));

    // R6
    all_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(s_pmask_i || ns_pmask_i) |-> !irq_valid_o);

    // R7
    s_threshold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid_o && $past(s_bpri_i) != '0) |-> (irq_level_o < $past(s_bpri_i)));

    // R7
    ns_threshold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid_o && $past(ns_bpri_i) != '0) |-> (irq_level_o < $past(ns_bpri_i)));

    // R9
    preempt_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        preempt_o |-> irq_valid_o);

    // R9
    preempt_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid_o |-> (preempt_o == ({1'b0, irq_level_o} < $past(cur_level_i))));

    // R10
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_valid_o |-> (irq_id_o == '0 && !irq_ns_o && irq_level_o == '0));

    // R1
    secure_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid_o && !irq_ns_o) |-> (irq_level_o[PAD_W-1:0] == '0));

    // R3
    remap_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid_o && irq_ns_o && $past(remap_w))
            |-> (irq_level_o[LVL_W-1] && irq_level_o[PAD_W-2:0] == '0));

endmodule

bind irq_sec_arbiter irq_sec_arbiter_chk #(.NUM_LINES(NUM_LINES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wr_i    (cfg_wr_i),
    .cfg_sec_i   (cfg_sec_i),
    .remap_w     (remap_w),
    .tgt_w       (tgt_w),
    .s_pmask_i   (s_pmask_i),
    .ns_pmask_i  (ns_pmask_i),
    .s_bpri_i    (s_bpri_i),
    .ns_bpri_i   (ns_bpri_i),
    .cur_level_i (cur_level_i),
    .irq_valid_o (irq_valid_o),
    .irq_id_o    (irq_id_o),
    .irq_ns_o    (irq_ns_o),
    .irq_level_o (irq_level_o),
    .preempt_o   (preempt_o)
);

// File: tb/irq_sec_arbiter_tb.sv
module irq_sec_arbiter_tb;

    localparam int N = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  pend = '0;
    logic [N*3-1:0] prio = '0;
    logic [8:0]    cur_level = 9'h100;
    logic          s_pmask = 1'b0, ns_pmask = 1'b0;
    logic [7:0]    s_bpri = '0, ns_bpri = '0;
    logic          cfg_wr = 1'b0, cfg_sec = 1'b0, cfg_sel = 1'b0;
    logic [N-1:0]  cfg_wdata = '0;
    logic [N-1:0]  cfg_rdata;
    logic          irq_valid, irq_ns, preempt;
    logic [4:0]    irq_id;
    logic [7:0]    irq_level;

    int n_vec = 0, n_bad = 0;
    string phase = "reset";

    // reference state and expectations
    bit        m_remap;
    bit [N-1:0] m_tgt;
    bit        e_valid, e_ns, e_pre;
    int        e_id, e_level;

    always #2 clk = ~clk;

    irq_sec_arbiter u_dut (
        .clk(clk), .rst_n(rst_n), .pend_i(pend), .prio_i(prio),
        .cur_level_i(cur_level), .s_pmask_i(s_pmask), .ns_pmask_i(ns_pmask),
        .s_bpri_i(s_bpri), .ns_bpri_i(ns_bpri), .cfg_wr_i(cfg_wr),
        .cfg_sec_i(cfg_sec), .cfg_sel_i(cfg_sel), .cfg_wdata_i(cfg_wdata),
        .cfg_rdata_o(cfg_rdata), .irq_valid_o(irq_valid), .irq_id_o(irq_id),
        .irq_ns_o(irq_ns), .irq_level_o(irq_level), .preempt_o(preempt)
    );

    function automatic int level_of(int p, bit ns, bit rm);
        if (ns && rm) return 128 + p * 16;
        return p * 32;
    endfunction

    // Reference model: evaluated at each edge from the values present before it
    always @(posedge clk) begin
        if (!rst_n) begin
            m_remap = 0; m_tgt = '0;
            e_valid = 0; e_ns = 0; e_pre = 0; e_id = 0; e_level = 0;
        end else begin
            int best_lvl; int best_id;
            best_lvl = 1000; best_id = -1;
            for (int i = 0; i < N; i++) begin
                int lv;
                lv = level_of(int'(prio[i*3 +: 3]), m_tgt[i], m_remap);
                if (!pend[i] || s_pmask || ns_pmask) continue;
                if (s_bpri != 0 && lv >= int'(s_bpri)) continue;
                if (ns_bpri != 0 && lv >= int'(ns_bpri)) continue;
                if (lv < best_lvl) begin best_lvl = lv; best_id = i; end
            end
            if (best_id < 0) begin
                e_valid = 0; e_ns = 0; e_pre = 0; e_id = 0; e_level = 0;
            end else begin
                e_valid = 1; e_id = best_id; e_level = best_lvl;
                e_ns = m_tgt[best_id];
                e_pre = best_lvl < int'(cur_level);
            end
            if (cfg_wr && cfg_sec) begin
                if (!cfg_sel) m_remap = cfg_wdata[0];
                else          m_tgt   = cfg_wdata;
            end
        end
    end

    task automatic check(bit ok, string req, int act, int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s [%s] t=%0t actual=%0h expected=%0h", req, phase, $time, act, exp);
        end
    endtask

    // Per-cycle comparison away from the active edge
    always @(negedge clk) begin
        check(irq_valid == e_valid, "R6/R7/R10 grant valid", irq_valid, e_valid);
        check(int'(irq_id) == e_id, "R8 winner index", irq_id, e_id);
        check(int'(irq_level) == e_level, "R1/R3 effective level", irq_level, e_level);
        check(irq_ns == e_ns, "R4 winner state", irq_ns, e_ns);
        check(preempt == e_pre, "R9 preempt", preempt, e_pre);
    end

    task automatic tick(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg_write(bit sec, bit sel, logic [N-1:0] d);
        cfg_wr = 1; cfg_sec = sec; cfg_sel = sel; cfg_wdata = d;
        tick();
        cfg_wr = 0; cfg_sec = 0;
    endtask

    task automatic set_prio(int line, int p);
        prio[line*3 +: 3] = 3'(p);
    endtask

    task automatic rd_check(bit sel, logic [N-1:0] exp, string req);
        cfg_sel = sel;
        #1;
        check(cfg_rdata == exp, req, cfg_rdata, exp);
    endtask

    bit done = 0;

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        tick(3);
        // R2 R4 reset values through the read port
        rd_check(1'b0, '0, "R2 remap reset");
        rd_check(1'b1, '0, "R4 target reset");
        rst_n = 1;
        tick(2);

        phase = "single line";           // R1
        pend = 32'h0000_0100; set_prio(8, 5); tick(3);

        phase = "priority order";        // R1
        pend = 32'h0000_0F00; set_prio(9, 3); set_prio(10, 1); set_prio(11, 6); tick(3);

        phase = "tie lowest index";      // R8
        set_prio(9, 1); tick(3);
        pend = 32'h8000_0001; set_prio(0, 7); set_prio(31, 7); tick(3);

        phase = "ns write ignored";      // R5
        cfg_write(1'b0, 1'b1, 32'hFFFF_FFFF);
        cfg_write(1'b0, 1'b0, 32'h1);
        tick();
        rd_check(1'b1, '0, "R5 target unchanged");
        rd_check(1'b0, '0, "R5 remap unchanged");

        phase = "secure targets, shared space"; // R2 R4 R11
        cfg_write(1'b1, 1'b1, 32'h0000_0006);
        tick();
        rd_check(1'b1, 32'h0000_0006, "R11 target word");
        pend = 32'h0000_0007; set_prio(0, 3); set_prio(1, 2); set_prio(2, 2); tick(3);

        phase = "remap on";              // R3 R11
        cfg_write(1'b1, 1'b0, 32'hFFFF_FFFF);
        tick();
        rd_check(1'b0, 32'h1, "R11 control word");
        tick(2);
        // non-secure raw 0 -> 0x80 ties with secure raw 4 at a higher index
        pend = 32'h0000_0012; set_prio(1, 0); set_prio(4, 4); tick(3);
        set_prio(4, 5); tick(3);
        pend = 32'h0000_0006; set_prio(1, 7); set_prio(2, 3); tick(3);

        phase = "all-block masks";       // R6
        pend = 32'h0000_0013; set_prio(0, 2);
        s_pmask = 1; tick(3); s_pmask = 0;
        ns_pmask = 1; tick(3); ns_pmask = 0; tick(2);

        phase = "thresholds";            // R7
        cfg_write(1'b1, 1'b0, 32'h0);
        pend = 32'h0000_0003; set_prio(0, 3); set_prio(1, 2);
        ns_bpri = 8'h60; tick(3);        // blocks secure line 0 at 0x60
        ns_bpri = 8'h40; tick(3);        // blocks both
        ns_bpri = 0; s_bpri = 8'h41; tick(3);
        s_bpri = 0; tick(2);

        phase = "preempt";               // R9
        cur_level = 9'h040; tick(3);
        cur_level = 9'h041; tick(3);
        cur_level = 9'h000; tick(3);
        cur_level = 9'h100; tick(2);

        phase = "idle";                  // R10
        pend = '0; tick(3);

        phase = "random";
        for (int c = 0; c < 4000; c++) begin
            pend = $urandom() & $urandom();
            prio = {$urandom(), $urandom(), $urandom()};
            cur_level = 9'($urandom_range(0, 256));
            s_pmask  = ($urandom_range(0, 15) == 0);
            ns_pmask = ($urandom_range(0, 15) == 0);
            s_bpri  = ($urandom_range(0, 3) == 0) ? 8'($urandom()) : 8'h0;
            ns_bpri = ($urandom_range(0, 3) == 0) ? 8'($urandom()) : 8'h0;
            cfg_wr  = ($urandom_range(0, 7) == 0);
            cfg_sec = $urandom_range(0, 1);
            cfg_sel = $urandom_range(0, 1);
            cfg_wdata = $urandom();
            tick();
        end
        cfg_wr = 0;
        tick(3);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule